// File: doc/BRIEF.md
# Four-Lane Histogram Equalization Remapper

This block takes the cumulative count table built by an earlier histogram pass and uses it to replace every pixel of the same frame with its equalized intensity. The frame is streamed a second time, four 8-bit pixels per beat, over a valid/ready handshake. Each output value is the pixel's cumulative count minus the smallest non-zero cumulative count, scaled by the top intensity level (255) and divided by the frame area minus that same minimum. The result is truncated toward zero and clamped to 0..255.

The cumulative table is loaded through a simple write port before the frame is streamed. The frame height, the frame width and the minimum cumulative count are static configuration inputs. All three must stay unchanged while pixels are in flight. The default sizing covers frames up to 4095 by 4095, which includes the 512 by 512 frame the block was sized for.

Arithmetic runs in a three-stage pipeline with one shared advance enable. The stages are table lookup, then subtract-and-multiply, then divide-and-clamp. A stalled output freezes every stage together.

Top module: `hist_eq_remap`

## Requirements
- R1: For an input pixel v, with T the loaded table and F = cfg_rows × cfg_cols, the lane output is floor((T[v] − cfg_cdf_min) × 255 / (F − cfg_cdf_min)) whenever cfg_cdf_min < F and T[v] ≥ cfg_cdf_min.
- R2: The lane output is 0 when T[v] < cfg_cdf_min. It is 255 when the quotient of R1 exceeds 255.
- R3: When cfg_cdf_min ≥ F (single-intensity frame), every output pixel equals its input pixel unchanged.
- R4: With out_ready held high, a beat accepted on a rising edge appears on out_pix with out_valid high after the third rising edge, counting the accepting edge as the first.
- R5: Lane i occupies bits [8i+7:8i] of both in_pix and out_pix, and lane i of an output beat is computed from lane i of the same input beat. Beats leave in the order they were accepted.
- R6: While out_valid is high and out_ready is low, out_valid and out_pix hold their values and in_ready is low. No beat is lost or duplicated.
- R7: During reset and right after its release, out_valid is low and in_ready is high.
- R8: A table write of value d to entry a (cdf_we high for one edge) sets T[a] = d for every beat accepted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_rows | input | 12 | Frame height in pixels |
| cfg_cols | input | 12 | Frame width in pixels |
| cfg_cdf_min | input | 24 | Smallest non-zero cumulative count of the frame |
| cdf_we | input | 1 | Table write strobe |
| cdf_waddr | input | 8 | Table entry (intensity) to write |
| cdf_wdata | input | 24 | Cumulative count for that intensity |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted on this edge when high together with in_valid |
| in_pix | input | 32 | Four input pixels, lane 0 in the low byte |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_pix | output | 32 | Four equalized pixels, lane 0 in the low byte |

## Verification
With no backpressure, each accepted beat is due on the output three rising edges after acceptance. The latency check samples out_valid at the falling edges after the first, second and third edge and expects low, low, high. Every other result is checked through a scoreboard. Expected beats are queued at the falling edge before the edge that accepts them, and they are retired at the falling edge before the edge that consumes them. The check therefore follows the handshake rather than a fixed cycle count, and it still holds under random backpressure. The stall check fills all three stages with out_ready low. It then watches out_pix and in_ready over several falling edges.

// File: rtl/hist_eq_pkg.sv
package hist_eq_pkg;

  // How the final stage forms a lane result.
  typedef enum logic [1:0] {
    KIND_SCALE = 2'd0,  // quotient, saturated to the top level
    KIND_FLOOR = 2'd1,  // count below the frame minimum: black
    KIND_COPY  = 2'd2   // degenerate frame: pixel passes through
  } eq_kind_e;

  localparam int unsigned PIPE_STAGES = 3;

endpackage

// File: rtl/hist_eq_cdf_table.sv
module hist_eq_cdf_table #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned CNT_W = 24,
  parameter int unsigned LANES = 4
) (
  input  logic                   clk,
  input  logic                   wr_en,
  input  logic [PIX_W-1:0]       wr_addr,
  input  logic [CNT_W-1:0]       wr_data,
  input  logic                   rd_en,
  input  logic [LANES*PIX_W-1:0] rd_addr,
  output logic [LANES*CNT_W-1:0] rd_data
);

  localparam int unsigned DEPTH = 1 << PIX_W;

  // One copy per lane so every lane gets its own read port.
  for (genvar g = 0; g < LANES; g++) begin : g_copy
    logic [CNT_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0] rd_q;
    logic [PIX_W-1:0] addr;

    assign addr = rd_addr[g*PIX_W +: PIX_W];

    always_ff @(posedge clk) begin
      if (wr_en) begin
        mem[wr_addr] <= wr_data;
      end
    end

    always_ff @(posedge clk) begin
      if (rd_en) begin
        rd_q <= mem[addr];
      end
    end

    assign rd_data[g*CNT_W +: CNT_W] = rd_q;
  end

endmodule

// File: rtl/hist_eq_pipe_ctrl.sv
module hist_eq_pipe_ctrl #(
  parameter int unsigned STAGES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              out_ready,
  output logic              in_ready,
  output logic              adv,
  output logic [STAGES-1:0] vld_q
);

  logic [STAGES-1:0] vld_d;

  always_comb begin
    adv   = !vld_q[STAGES-1] || out_ready;
    vld_d = vld_q;
    if (adv) begin
      vld_d = {vld_q[STAGES-2:0], in_valid};
    end
  end

  assign in_ready = adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  AST_FROZEN_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q[STAGES-1] && !out_ready) |=> (vld_q == $past(vld_q))); // R6

endmodule

// File: rtl/hist_eq_lane.sv
module hist_eq_lane
  import hist_eq_pkg::*;
#(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [PIX_W-1:0] pix_s1,
  input  logic [CNT_W-1:0] cdf_s1,
  input  logic [CNT_W-1:0] cdf_min,
  input  logic [CNT_W-1:0] denom,
  input  logic             pass_mode,
  output logic [PIX_W-1:0] res_q
);

  localparam int unsigned NUM_W     = CNT_W + PIX_W;
  localparam int unsigned LEVEL_MAX = (1 << PIX_W) - 1;

  // Stage 2: subtract and scale.
  eq_kind_e         kind_d, kind_q;
  logic [NUM_W-1:0] num_d, num_q;
  logic [PIX_W-1:0] pix_s2;
  logic [CNT_W-1:0] diff;

  always_comb begin
    diff  = cdf_s1 - cdf_min;
    num_d = NUM_W'(diff) * NUM_W'(LEVEL_MAX);
    if (pass_mode) begin
      kind_d = KIND_COPY;
    end else if (cdf_s1 < cdf_min) begin
      kind_d = KIND_FLOOR;
    end else begin
      kind_d = KIND_SCALE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= KIND_FLOOR;
      num_q  <= '0;
      pix_s2 <= '0;
    end else if (adv) begin
      kind_q <= kind_d;
      num_q  <= num_d;
      pix_s2 <= pix_s1;
    end
  end

  // Stage 3: divide, truncate, clamp.
  logic [NUM_W-1:0] div_den, quot;
  logic [PIX_W-1:0] res_d;

  always_comb begin
    div_den = (denom == '0) ? NUM_W'(1) : NUM_W'(denom);
    quot    = num_q / div_den;
    unique case (kind_q)
      KIND_COPY:  res_d = pix_s2;
      KIND_FLOOR: res_d = '0;
      default:    res_d = (quot > NUM_W'(LEVEL_MAX)) ? PIX_W'(LEVEL_MAX)
                                                     : quot[PIX_W-1:0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (adv) begin
      res_q <= res_d;
    end
  end

  AST_FLOOR_IS_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && kind_q == KIND_FLOOR) |=> (res_q == '0)); // R2
  AST_COPY_KEEPS_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && kind_q == KIND_COPY) |=> (res_q == $past(pix_s2))); // R3

endmodule

// File: rtl/hist_eq_remap.sv
module hist_eq_remap
  import hist_eq_pkg::*;
#(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned LANES = 4,
  parameter int unsigned DIM_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [DIM_W-1:0]       cfg_rows,
  input  logic [DIM_W-1:0]       cfg_cols,
  input  logic [2*DIM_W-1:0]     cfg_cdf_min,
  input  logic                   cdf_we,
  input  logic [PIX_W-1:0]       cdf_waddr,
  input  logic [2*DIM_W-1:0]     cdf_wdata,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [LANES*PIX_W-1:0] in_pix,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [LANES*PIX_W-1:0] out_pix
);

  localparam int unsigned CNT_W = 2 * DIM_W;
  localparam int unsigned BUS_W = LANES * PIX_W;

  // Reset: asserted at once, released on the clock.
  logic rst_meta, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_core_n <= rst_meta;
    end
  end

  // Frame geometry.
  logic [CNT_W-1:0] frame_px, denom;
  logic             pass_mode;
  always_comb begin
    frame_px  = CNT_W'(cfg_rows) * CNT_W'(cfg_cols);
    pass_mode = (cfg_cdf_min >= frame_px);
    denom     = frame_px - cfg_cdf_min;
  end

  logic                  adv;
  logic [PIPE_STAGES-1:0] vld_q;

  hist_eq_pipe_ctrl #(.STAGES(PIPE_STAGES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .adv       (adv),
    .vld_q     (vld_q)
  );

  // Stage 1: table lookup, pixel carried alongside.
  logic [BUS_W-1:0]       pix_s1;
  logic [LANES*CNT_W-1:0] cdf_s1;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      pix_s1 <= '0;
    end else if (adv) begin
      pix_s1 <= in_pix;
    end
  end

  hist_eq_cdf_table #(.PIX_W(PIX_W), .CNT_W(CNT_W), .LANES(LANES)) u_tab (
    .clk     (clk),
    .wr_en   (cdf_we),
    .wr_addr (cdf_waddr),
    .wr_data (cdf_wdata),
    .rd_en   (adv),
    .rd_addr (in_pix),
    .rd_data (cdf_s1)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    hist_eq_lane #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_lane (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .adv       (adv),
      .pix_s1    (pix_s1[g*PIX_W +: PIX_W]),
      .cdf_s1    (cdf_s1[g*CNT_W +: CNT_W]),
      .cdf_min   (cfg_cdf_min),
      .denom     (denom),
      .pass_mode (pass_mode),
      .res_q     (out_pix[g*PIX_W +: PIX_W])
    );
  end

  assign out_valid = vld_q[PIPE_STAGES-1];

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix))); // R6
  AST_NO_ACCEPT_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_core_n)
    (out_valid && !out_ready) |-> !in_ready); // R6
  AST_LATENCY_THREE: assert property (@(posedge clk) disable iff (!rst_core_n)
    (in_valid && in_ready) ##1 out_ready ##1 out_ready |=> out_valid); // R4
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    $rose(rst_core_n) |-> !out_valid); // R7

endmodule

// File: tb/hist_eq_remap_tb.sv
module hist_eq_remap_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] cfg_rows, cfg_cols;
  logic [23:0] cfg_cdf_min;
  logic        cdf_we;
  logic [7:0]  cdf_waddr;
  logic [23:0] cdf_wdata;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [31:0] in_pix, out_pix;

  always #4 clk = ~clk;  // 125 MHz

  hist_eq_remap u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_rows(cfg_rows), .cfg_cols(cfg_cols),
    .cfg_cdf_min(cfg_cdf_min), .cdf_we(cdf_we), .cdf_waddr(cdf_waddr),
    .cdf_wdata(cdf_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .out_valid(out_valid), .out_ready(out_ready),
    .out_pix(out_pix)
  );

  int total = 0;
  int bad   = 0;

  // Bench copy of the table and the reference model.
  logic [23:0] tb_cdf [256];
  int          hist   [256];

  function automatic logic [7:0] ref_px(input logic [7:0] v);
    longint fp, num, q;
    fp = longint'(cfg_rows) * longint'(cfg_cols);
    if (longint'(cfg_cdf_min) >= fp) return v;
    if (tb_cdf[v] < cfg_cdf_min) return 8'd0;
    num = (longint'(tb_cdf[v]) - longint'(cfg_cdf_min)) * 255;
    q   = num / (fp - longint'(cfg_cdf_min));
    return (q > 255) ? 8'd255 : q[7:0];
  endfunction

  function automatic int ref_tag(input logic [7:0] v);
    longint fp, num;
    fp = longint'(cfg_rows) * longint'(cfg_cols);
    if (longint'(cfg_cdf_min) >= fp) return 3;  // R3
    if (tb_cdf[v] < cfg_cdf_min) return 2;      // R2
    num = (longint'(tb_cdf[v]) - longint'(cfg_cdf_min)) * 255;
    if (num / (fp - longint'(cfg_cdf_min)) > 255) return 2;
    return 1;                                     // R1
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Scoreboard: expected values fixed when the beat is accepted (R5 order).
  logic [31:0] sb_exp [1024];
  int          sb_tag [1024][4];
  int          wr_ptr = 0;
  int          rd_ptr = 0;
  int          tag_override = 0;

  always @(negedge clk) begin
    if (rst_n && in_valid && in_ready) begin
      for (int l = 0; l < 4; l++) begin
        sb_exp[wr_ptr % 1024][l*8 +: 8] = ref_px(in_pix[l*8 +: 8]);
        sb_tag[wr_ptr % 1024][l] = (tag_override != 0) ? tag_override
                                                      : ref_tag(in_pix[l*8 +: 8]);
      end
      wr_ptr++;
    end
    if (rst_n && out_valid && out_ready) begin
      if (rd_ptr >= wr_ptr) begin
        check(1'b0, "R6", "unexpected beat", longint'(out_pix), 0);
      end else begin
        for (int l = 0; l < 4; l++) begin
          check(out_pix[l*8 +: 8] == sb_exp[rd_ptr % 1024][l*8 +: 8],
                $sformatf("R%0d(R5 lane %0d)", sb_tag[rd_ptr % 1024][l], l),
                "pixel", longint'(out_pix[l*8 +: 8]),
                longint'(sb_exp[rd_ptr % 1024][l*8 +: 8]));
        end
        rd_ptr++;
      end
    end
  end

  // Output backpressure: 0 = always ready, 1 = random, 2 = never.
  int ready_mode = 0;
  always @(posedge clk) begin
    #2;
    case (ready_mode)
      0:       out_ready = 1'b1;
      1:       out_ready = ($urandom % 4) != 0;
      default: out_ready = 1'b0;
    endcase
  end

  // Watchdog.
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic write_entry(input logic [7:0] a, input logic [23:0] d);  // R8
    cdf_we = 1'b1; cdf_waddr = a; cdf_wdata = d; tb_cdf[a] = d;
    @(posedge clk); #2;
    cdf_we = 1'b0;
  endtask

  task automatic load_frame(input int rows, input int cols,
                            input int lo, input int span);
    int acc;
    int mn;
    for (int v = 0; v < 256; v++) hist[v] = 0;
    for (int i = 0; i < rows * cols; i++) hist[lo + ($urandom % span)]++;
    acc = 0; mn = 0;
    for (int v = 0; v < 256; v++) begin
      acc += hist[v];
      if (mn == 0 && acc != 0) mn = acc;
      write_entry(8'(v), 24'(acc));
    end
    cfg_rows = 12'(rows); cfg_cols = 12'(cols); cfg_cdf_min = 24'(mn);
  endtask

  task automatic send(input logic [31:0] p);
    in_pix = p; in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #2;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    ready_mode = 0;
    for (int i = 0; i < 8; i++) @(posedge clk);
    #2;
    check(rd_ptr == wr_ptr, "R6", "beats retired", rd_ptr, wr_ptr);
  endtask

  logic [31:0] held;

  initial begin
    void'($urandom(32'd20211));
    rst_n = 1'b0; in_valid = 1'b0; in_pix = '0; cdf_we = 1'b0;
    cdf_waddr = '0; cdf_wdata = '0; out_ready = 1'b1;
    cfg_rows = 12'd1; cfg_cols = 12'd1; cfg_cdf_min = 24'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R7", "out_valid in reset", out_valid, 0);
    check(in_ready == 1'b1, "R7", "in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    @(negedge clk);
    check(out_valid == 1'b0, "R7", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R7", "in_ready after reset", in_ready, 1);
    @(posedge clk); #2;

    // Frame at the reference size, intensities clustered in 40..199.
    load_frame(512, 512, 40, 160);

    // R4: three-edge latency with no backpressure.
    send({8'd60, 8'd120, 8'd180, 8'd10});
    @(negedge clk);
    check(out_valid == 1'b0, "R4", "valid after edge 1", out_valid, 0);
    @(negedge clk);
    check(out_valid == 1'b0, "R4", "valid after edge 2", out_valid, 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R4", "valid after edge 3", out_valid, 1);
    @(posedge clk); #2;

    // R5: distinct lanes, each lane checked against its own input byte.
    send({8'd199, 8'd40, 8'd100, 8'd150});
    @(negedge clk); @(negedge clk); @(negedge clk);
    check(out_pix[7:0] == ref_px(8'd150), "R5", "lane0", out_pix[7:0], ref_px(8'd150));
    check(out_pix[31:24] == ref_px(8'd199), "R5", "lane3", out_pix[31:24], ref_px(8'd199));
    @(posedge clk); #2;

    // Random beats under random backpressure (R1, R2, R5).
    ready_mode = 1;
    for (int b = 0; b < 300; b++) begin
      send($urandom);
      if ($urandom % 3 == 0) begin
        @(posedge clk); #2;
      end
    end
    drain();

    // R6: fill all stages with the output blocked.
    ready_mode = 2;
    @(posedge clk); #2;
    send({8'd41, 8'd42, 8'd43, 8'd44});
    send({8'd91, 8'd92, 8'd93, 8'd94});
    send({8'd191, 8'd192, 8'd193, 8'd194});
    @(negedge clk);
    check(out_valid == 1'b1, "R6", "valid while blocked", out_valid, 1);
    check(in_ready == 1'b0, "R6", "in_ready while blocked", in_ready, 0);
    held = out_pix;
    repeat (3) @(negedge clk);
    check(out_pix == held, "R6", "held data", out_pix, held);
    check(in_ready == 1'b0, "R6", "in_ready still low", in_ready, 0);
    @(posedge clk); #2;
    drain();

    // R8 and R2 saturation: rewrite one entry above the frame area.
    write_entry(8'd77, 24'd300000);
    tag_override = 8;
    send({8'd77, 8'd77, 8'd77, 8'd77});
    tag_override = 0;
    drain();

    // Smaller frame, full intensity range, random backpressure.
    load_frame(20, 30, 0, 256);
    ready_mode = 1;
    for (int b = 0; b < 120; b++) send($urandom);
    drain();

    // R3: single-intensity frame, the minimum equals the frame area.
    for (int v = 0; v < 256; v++) write_entry(8'(v), 24'd16);
    cfg_rows = 12'd4; cfg_cols = 12'd4; cfg_cdf_min = 24'd16;
    tag_override = 3;
    for (int b = 0; b < 20; b++) send($urandom);
    send({8'd0, 8'd255, 8'd1, 8'd128});
    tag_override = 0;
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule